// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block resolves a translation miss by reading page-table entries from memory one level at a time. A requester hands it a 48-bit virtual address, the frame number of the top-level table and a flag that says whether the access comes from user mode. The walker then issues one 64-bit read per level over a simple request / response-valid port. It returns the physical frame and the page size together with the combined write and user permissions, or it reports a not-present fault or an access fault.

Each level uses a 9-bit slice of the virtual address as its table index. Each entry supplies the frame of the next table. An entry with its large-page bit set on the second or third read ends the walk early with a 1 GB or 2 MB page. Only one read is ever outstanding. A start request that arrives while a walk is running has no effect.

Top module: `ptw_core`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `mem_req_o` are all low.
- R2: Read n (n = 1..4) targets address `{base, 12'b0} + 8*idx`. The index `idx` is `va[47:39]`, `va[38:30]`, `va[29:21]` or `va[20:12]` for n = 1, 2, 3 or 4. The first base is `root_pfn_i`. Each later base is bits 51:12 of the previous entry. The address stays stable while its response is pending.
- R3: `mem_req_o` is high for exactly one cycle per read. No new request is issued before `mem_rvalid_i` has returned the previous entry.
- R4: A walk that does not end early performs exactly four reads. Its frame is bits 51:12 of the fourth entry and its size code is 0 (4 KB).
- R5: An entry with bit 0 (present) clear ends the walk with `fault_np_o`. No further reads follow.
- R6: When `user_i` is 1 and a present entry has bit 2 (user) clear, the walk ends at that level with `fault_acc_o`. The present check takes priority.
- R7: Bit 7 (large page) set on the second read gives size code 2 (1 GB) with frame = entry bits 51:30. The same bit on the third read gives size code 1 (2 MB) with frame = entry bits 51:21. The frame is right-justified in `frame_o`. Bit 7 on the first or fourth read is ignored.
- R8: `writable_o` and `user_o` are the AND of entry bits 1 and 2 over every entry the walk read.
- R9: `start_i` is ignored while `busy_o` is high. The running walk keeps its address, its reads and its result.
- R10: `done_o` is a one-cycle pulse, and `busy_o` is low in that cycle. The result outputs hold until the next start. After a fault, `frame_o`, `size_o`, `writable_o` and `user_o` are zero, and the two fault flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a walk (taken only when idle) |
| va_i | input | 48 | Virtual address to translate |
| root_pfn_i | input | 40 | Frame number of the top-level table |
| user_i | input | 1 | Access is from user mode |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_np_o | output | 1 | Walk ended on a non-present entry |
| fault_acc_o | output | 1 | Walk ended on a user-access violation |
| frame_o | output | 40 | Physical frame, in units of the resulting page size |
| size_o | output | 2 | 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| writable_o | output | 1 | AND of write bits across the walk |
| user_o | output | 1 | AND of user bits across the walk |
| mem_req_o | output | 1 | One-cycle read request |
| mem_addr_o | output | 52 | Physical address of the entry to read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Entry returned by memory |

## Verification
The assertions assume the memory side returns `mem_rvalid_i` only while a read is pending, and only once per request. They also assume it never answers in the same cycle as the request. The bench's responder follows this rule: it raises `mem_rvalid_i` for one cycle, one to three cycles after each request. The latency varies from walk to walk. The stimulus sweeps every combination of write and user bits across four levels in both privilege modes, a missing entry at each level, and the large-page bit at each level. Every entry carries noise in its ignored bit ranges, so any slicing error changes the result.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } walk_st_e;

    // Entry flag positions; the walk decodes exactly these bits
    localparam int PTE_PRESENT_BIT = 0;
    localparam int PTE_WRITE_BIT   = 1;
    localparam int PTE_USER_BIT    = 2;
    localparam int PTE_LARGE_BIT   = 7;

    // Bit offset of the index field used at walk step lvl (0 = top table)
    function automatic int lvl_shift(int page_shift, int idx_w, int levels, int lvl);
        return page_shift + idx_w * (levels - 1 - lvl);
    endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int VA_W       = 48,
    parameter int PA_W       = 52,
    parameter int DATA_W     = 64,
    parameter int IDX_W      = 9,
    parameter int LEVELS     = 4,
    parameter int PAGE_SHIFT = 12,
    localparam int PFN_W     = PA_W - PAGE_SHIFT,
    localparam int LVL_W     = $clog2(LEVELS)
) (
    input  logic [PFN_W-1:0] base_i,
    input  logic [VA_W-1:0]  va_i,
    input  logic [LVL_W-1:0] lvl_i,
    output logic [PA_W-1:0]  addr_o
);
    localparam int ENTRY_SH = $clog2(DATA_W / 8);

    logic [IDX_W-1:0] idx_by_lvl [LEVELS];
    logic [IDX_W-1:0] idx;

    for (genvar g = 0; g < LEVELS; g++) begin : g_idx
        localparam int SH = ptw_pkg::lvl_shift(PAGE_SHIFT, IDX_W, LEVELS, g);
        assign idx_by_lvl[g] = va_i[SH +: IDX_W];
    end

    assign idx    = idx_by_lvl[lvl_i];
    assign addr_o = {base_i, {PAGE_SHIFT{1'b0}}} + (PA_W'(idx) << ENTRY_SH);

endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
    parameter int PA_W       = 52,
    parameter int DATA_W     = 64,
    parameter int IDX_W      = 9,
    parameter int LEVELS     = 4,
    parameter int PAGE_SHIFT = 12,
    localparam int PFN_W     = PA_W - PAGE_SHIFT,
    localparam int LVL_W     = $clog2(LEVELS)
) (
    input  logic [DATA_W-1:0] pte_i,
    input  logic [LVL_W-1:0]  lvl_i,
    output logic              present_o,
    output logic              write_o,
    output logic              user_o,
    output logic              leaf_large_o,
    output logic [PFN_W-1:0]  next_pfn_o,
    output logic [PFN_W-1:0]  large_frame_o
);
    logic [PFN_W-1:0] frame_by_lvl [LEVELS];
    logic             large_allowed;

    for (genvar g = 0; g < LEVELS; g++) begin : g_frame
        localparam int SH = ptw_pkg::lvl_shift(PAGE_SHIFT, IDX_W, LEVELS, g);
        assign frame_by_lvl[g] = PFN_W'(pte_i[PA_W-1:SH]);
    end

    // Large pages terminate only on the intermediate steps, never first or last
    assign large_allowed = (lvl_i != '0) && (lvl_i < LVL_W'(LEVELS - 1));

    assign present_o     = pte_i[ptw_pkg::PTE_PRESENT_BIT];
    assign write_o       = pte_i[ptw_pkg::PTE_WRITE_BIT];
    assign user_o        = pte_i[ptw_pkg::PTE_USER_BIT];
    assign leaf_large_o  = pte_i[ptw_pkg::PTE_LARGE_BIT] && large_allowed;
    assign next_pfn_o    = pte_i[PA_W-1:PAGE_SHIFT];
    assign large_frame_o = frame_by_lvl[lvl_i];

endmodule

// File: rtl/ptw_core.sv
module ptw_core #(
    parameter int VA_W       = 48,
    parameter int PA_W       = 52,
    parameter int DATA_W     = 64,
    parameter int IDX_W      = 9,
    parameter int LEVELS     = 4,
    parameter int PAGE_SHIFT = 12,
    localparam int PFN_W     = PA_W - PAGE_SHIFT,
    localparam int LVL_W     = $clog2(LEVELS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [VA_W-1:0]   va_i,
    input  logic [PFN_W-1:0]  root_pfn_i,
    input  logic              user_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              fault_np_o,
    output logic              fault_acc_o,
    output logic [PFN_W-1:0]  frame_o,
    output logic [LVL_W-1:0]  size_o,
    output logic              writable_o,
    output logic              user_o,
    output logic              mem_req_o,
    output logic [PA_W-1:0]   mem_addr_o,
    input  logic              mem_rvalid_i,
    input  logic [DATA_W-1:0] mem_rdata_i
);
    import ptw_pkg::*;

    typedef struct packed {
        walk_st_e         st;
        logic [LVL_W-1:0] lvl;
        logic [PFN_W-1:0] base;
        logic [VA_W-1:0]  va;
        logic             usr;
        logic             w_acc;
        logic             u_acc;
        logic             done;
        logic             f_np;
        logic             f_acc;
        logic [PFN_W-1:0] frame;
        logic [LVL_W-1:0] size;
        logic             wr;
        logic             us;
    } walk_s;

    walk_s q, d;

    logic             e_present, e_write, e_user, e_large;
    logic [PFN_W-1:0] e_next_pfn, e_large_frame;

    ptw_addr_gen #(
        .VA_W(VA_W), .PA_W(PA_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
        .LEVELS(LEVELS), .PAGE_SHIFT(PAGE_SHIFT)
    ) u_addr (
        .base_i (q.base),
        .va_i   (q.va),
        .lvl_i  (q.lvl),
        .addr_o (mem_addr_o)
    );

    ptw_pte_decode #(
        .PA_W(PA_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
        .LEVELS(LEVELS), .PAGE_SHIFT(PAGE_SHIFT)
    ) u_dec (
        .pte_i         (mem_rdata_i),
        .lvl_i         (q.lvl),
        .present_o     (e_present),
        .write_o       (e_write),
        .user_o        (e_user),
        .leaf_large_o  (e_large),
        .next_pfn_o    (e_next_pfn),
        .large_frame_o (e_large_frame)
    );

    always_comb begin
        logic w_new;
        logic u_new;
        d      = q;
        d.done = 1'b0;
        w_new  = q.w_acc & e_write;
        u_new  = q.u_acc & e_user;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st    = ST_REQ;
                    d.lvl   = '0;
                    d.base  = root_pfn_i;
                    d.va    = va_i;
                    d.usr   = user_i;
                    d.w_acc = 1'b1;
                    d.u_acc = 1'b1;
                    d.f_np  = 1'b0;
                    d.f_acc = 1'b0;
                    d.frame = '0;
                    d.size  = '0;
                    d.wr    = 1'b0;
                    d.us    = 1'b0;
                end
            end
            ST_REQ: begin
                d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rvalid_i) begin
                    if (!e_present) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                        d.f_np = 1'b1;
                    end else if (q.usr && !e_user) begin
                        d.st    = ST_IDLE;
                        d.done  = 1'b1;
                        d.f_acc = 1'b1;
                    end else if (e_large) begin
                        d.st    = ST_IDLE;
                        d.done  = 1'b1;
                        d.frame = e_large_frame;
                        d.size  = LVL_W'(LEVELS - 1) - q.lvl;
                        d.wr    = w_new;
                        d.us    = u_new;
                    end else if (q.lvl == LVL_W'(LEVELS - 1)) begin
                        d.st    = ST_IDLE;
                        d.done  = 1'b1;
                        d.frame = e_next_pfn;
                        d.size  = '0;
                        d.wr    = w_new;
                        d.us    = u_new;
                    end else begin
                        d.st    = ST_REQ;
                        d.lvl   = q.lvl + 1'b1;
                        d.base  = e_next_pfn;
                        d.w_acc = w_new;
                        d.u_acc = u_new;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy_o      = (q.st != ST_IDLE);
    assign done_o      = q.done;
    assign mem_req_o   = (q.st == ST_REQ);
    assign fault_np_o  = q.f_np;
    assign fault_acc_o = q.f_acc;
    assign frame_o     = q.frame;
    assign size_o      = q.size;
    assign writable_o  = q.wr;
    assign user_o      = q.us;

endmodule

// File: rtl/ptw_core_chk.sv
module ptw_core_chk #(
    parameter int PA_W   = 52,
    parameter int LEVELS = 4,
    parameter int PFN_W  = 40,
    parameter int LVL_W  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             fault_np_o,
    input logic             fault_acc_o,
    input logic [PFN_W-1:0] frame_o,
    input logic [LVL_W-1:0] size_o,
    input logic             writable_o,
    input logic             user_o,
    input logic             mem_req_o,
    input logic [PA_W-1:0]  mem_addr_o,
    input logic             mem_rvalid_i
);
    localparam int CNT_W = $clog2(LEVELS + 2);

    logic [CNT_W-1:0] rd_cnt;
    logic             pending;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt  <= '0;
            pending <= 1'b0;
        end else begin
            if (start_i && !busy_o) rd_cnt <= '0;
            else if (mem_req_o)     rd_cnt <= rd_cnt + 1'b1;
            if (mem_req_o)          pending <= 1'b1;
            else if (mem_rvalid_i)  pending <= 1'b0;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        $rose(rst_n) |-> (!busy_o && !done_o && !mem_req_o)); // R1
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> $stable(mem_addr_o)); // R2
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> !mem_req_o); // R3
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> !pending); // R3
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_req_o); // R3
    AST_READ_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cnt <= CNT_W'(LEVELS)); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R10
    AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault_np_o && fault_acc_o)); // R10
    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (fault_np_o || fault_acc_o)) |->
        (frame_o == '0 && size_o == '0 && !writable_o && !user_o)); // R10
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i && !done_o) |=> $stable(frame_o)); // R10

endmodule

bind ptw_core ptw_core_chk #(
    .PA_W(PA_W), .LEVELS(LEVELS), .PFN_W(PFN_W), .LVL_W(LVL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .fault_np_o   (fault_np_o),
    .fault_acc_o  (fault_acc_o),
    .frame_o      (frame_o),
    .size_o       (size_o),
    .writable_o   (writable_o),
    .user_o       (user_o),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i)
);

// File: tb/ptw_core_bench.sv
`timescale 1ns/1ps
module ptw_core_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [47:0] va_i = '0;
    logic [39:0] root_pfn_i = '0;
    logic        user_i = 1'b0;
    logic        busy_o, done_o, fault_np_o, fault_acc_o;
    logic [39:0] frame_o;
    logic [1:0]  size_o;
    logic        writable_o, user_o, mem_req_o;
    logic [51:0] mem_addr_o;
    logic        mem_rvalid_i = 1'b0;
    logic [63:0] mem_rdata_i = '0;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    ptw_core u_ptw_core (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .va_i(va_i),
        .root_pfn_i(root_pfn_i), .user_i(user_i), .busy_o(busy_o),
        .done_o(done_o), .fault_np_o(fault_np_o), .fault_acc_o(fault_acc_o),
        .frame_o(frame_o), .size_o(size_o), .writable_o(writable_o),
        .user_o(user_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i)
    );

    // Entries served for read 1..4 of the current walk
    logic [63:0] ent [4];

    // Expected outcome
    int          m_reads;
    logic        m_np, m_acc, m_w, m_u;
    logic [39:0] m_frame;
    logic [1:0]  m_size;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_ent(input logic [39:0] pfn, input bit p,
                                           input bit w, input bit u, input bit ps);
        return {12'hA5C, pfn, 4'h9, ps, 4'b1010, u, w, p};
    endfunction

    task automatic model(input bit usr);
        bit stop = 0;
        m_reads = 0; m_np = 0; m_acc = 0; m_frame = '0; m_size = '0;
        m_w = 1; m_u = 1;
        for (int l = 0; l < 4 && !stop; l++) begin
            m_reads = l + 1;
            if (!ent[l][0]) begin
                m_np = 1; stop = 1;
            end else if (usr && !ent[l][2]) begin
                m_acc = 1; stop = 1;
            end else begin
                m_w = m_w & ent[l][1];
                m_u = m_u & ent[l][2];
                if (ent[l][7] && l == 1) begin
                    m_frame = 40'(ent[l][51:30]); m_size = 2'd2; stop = 1;
                end else if (ent[l][7] && l == 2) begin
                    m_frame = 40'(ent[l][51:21]); m_size = 2'd1; stop = 1;
                end else if (l == 3) begin
                    m_frame = ent[l][51:12]; m_size = 2'd0;
                end
            end
        end
        if (m_np || m_acc) begin
            m_w = 0; m_u = 0;
        end
    endtask

    task automatic run_walk(input logic [47:0] va, input logic [39:0] root,
                            input bit usr, input int lat, input bit poke);
        int          reads = 0;
        bit          fin = 0;
        logic [39:0] base;
        logic [51:0] ea;
        logic [8:0]  idx;
        model(usr);
        @(negedge clk);
        start_i = 1; va_i = va; root_pfn_i = root; user_i = usr;
        @(negedge clk);
        start_i = 0; va_i = ~va; root_pfn_i = ~root; user_i = ~usr;
        for (int c = 0; c < 200 && !fin; c++) begin
            if (done_o) begin
                chk(reads == m_reads, "R4", "read count", 64'(reads), 64'(m_reads));
                chk(fault_np_o == m_np, "R5", "not-present fault", 64'(fault_np_o), 64'(m_np));
                chk(fault_acc_o == m_acc, "R6", "access fault", 64'(fault_acc_o), 64'(m_acc));
                chk(frame_o == m_frame, "R7", "frame", 64'(frame_o), 64'(m_frame));
                chk(size_o == m_size, "R7", "size code", 64'(size_o), 64'(m_size));
                chk(writable_o == m_w, "R8", "writable", 64'(writable_o), 64'(m_w));
                chk(user_o == m_u, "R8", "user", 64'(user_o), 64'(m_u));
                chk(!busy_o, "R10", "busy at done", 64'(busy_o), 64'd0);
                if (poke)
                    chk(reads == m_reads && frame_o == m_frame, "R9",
                        "walk disturbed by start", 64'(frame_o), 64'(m_frame));
                fin = 1;
            end else if (mem_req_o) begin
                base = (reads == 0) ? root : ent[reads-1][51:12];
                idx  = 9'(va >> (12 + 9 * (3 - reads)));
                ea   = {base, 12'h000} + 52'(idx) * 52'd8;
                chk(mem_addr_o == ea, "R2", "entry address", 64'(mem_addr_o), 64'(ea));
                if (reads >= 4) begin
                    chk(0, "R4", "extra read", 64'(reads + 1), 64'd4);
                    fin = 1;
                end else begin
                    for (int k = 0; k <= lat; k++) begin
                        @(negedge clk);
                        if (k == 0 && poke) begin
                            start_i = 1; va_i = va ^ 48'hFFFF_FFFF_F000; user_i = ~usr;
                        end
                        chk(!mem_req_o, "R3", "request while pending", 64'(mem_req_o), 64'd0);
                    end
                    start_i = 0;
                    mem_rvalid_i = 1; mem_rdata_i = ent[reads];
                    reads++;
                    @(negedge clk);
                    mem_rvalid_i = 0; mem_rdata_i = ~ent[0];
                end
            end else begin
                @(negedge clk);
            end
        end
        if (!fin) chk(0, "R10", "walk never completed", 64'd0, 64'd1);
        @(negedge clk);
        chk(!done_o, "R10", "done pulse width", 64'(done_o), 64'd0);
        chk(frame_o == m_frame && size_o == m_size, "R10", "result hold",
            64'(frame_o), 64'(m_frame));
    endtask

    task automatic fill(input int seed, input logic [3:0] p, input logic [3:0] w,
                        input logic [3:0] u, input logic [3:0] ps);
        for (int l = 0; l < 4; l++)
            ent[l] = mk_ent(40'h0_1234_5 + 40'(l) * 40'h11_1111 + 40'(seed) * 40'h3_0107,
                            p[l], w[l], u[l], ps[l]);
    endtask

    initial begin
        int walk = 0;
        logic [47:0] va;
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !mem_req_o, "R1", "reset outputs",
            {61'd0, busy_o, done_o, mem_req_o}, 64'd0);
        rst_n = 1;
        @(negedge clk);
        chk(!busy_o && !done_o && !mem_req_o, "R1", "idle after reset",
            {61'd0, busy_o, done_o, mem_req_o}, 64'd0);

        // Full walks: every write/user bit pattern in both modes (R4 R6 R8)
        for (int usr = 0; usr < 2; usr++)
            for (int w = 0; w < 16; w++)
                for (int u = 0; u < 16; u++) begin
                    va = 48'h8765_4321_0FED ^ (48'(walk) * 48'h0000_1357_9BDF);
                    fill(walk, 4'hF, 4'(w), 4'(u), 4'h0);
                    run_walk(va, 40'hA_BC00 + 40'(walk), bit'(usr), walk % 3, 0);
                    walk++;
                end

        // Missing entry at each level (R5), present checked before user (R6)
        for (int usr = 0; usr < 2; usr++)
            for (int f = 0; f < 4; f++) begin
                va = 48'hFFFF_FFFF_FFFF - 48'(walk) * 48'h0101_0101_1000;
                fill(walk, ~(4'b1 << f), 4'hF, 4'h0, 4'h0);
                run_walk(va, 40'h5_5000 + 40'(f), bit'(usr), (walk + f) % 3, 0);
                walk++;
            end

        // Large-page bit at each level, alone and paired (R7)
        for (int ps = 0; ps < 16; ps++)
            for (int w = 0; w < 4; w++) begin
                va = 48'h0123_4567_89AB + 48'(walk) * 48'h0000_4020_1000;
                fill(walk, 4'hF, {2'b11, 2'(w)}, 4'hF, 4'(ps));
                run_walk(va, 40'h7_7000 + 40'(ps), bit'(w & 1), walk % 3, 0);
                walk++;
            end

        // Start pulses during busy walks are ignored (R9)
        for (int k = 0; k < 6; k++) begin
            fill(walk, 4'hF, 4'hF, 4'hF, (k == 3) ? 4'b0100 : 4'h0);
            run_walk(48'h3C3C_5A5A_0F0F + 48'(k) * 48'h1_0000_0000, 40'h9_0000,
                     bit'(k & 1), k % 3, 1);
            walk++;
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL R10 watchdog expired: actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule